// File: doc/BRIEF.md
# Serial Programming Entry Sequencer

This block is the host side of a two-wire programming link to a small serial memory target. On a start request it fetches the first word of a 16-word configuration image through a valid/ready handshake. It then plays one of three timed entry patterns on the target's clock, data and side-band lines, and can wait out a bulk-erase interval. After that it shifts the whole image out, least significant bit first and one word after another, with a target write-time gap between words. Every phase length is a cycle-count parameter, so one netlist serves targets with different timing.

The image layout belongs to the supplier of the words, not to this block. Wider fields such as the 64-bit key, the 60-bit seed with its configuration nibble, the two option words, the 32-bit serial number and the 64-bit user area sit least-significant word first. Because words go out in address order, each field reaches the target low word first. The block itself moves words in order and does not interpret them.

Top module: `prog_entry_seq`

## Requirements
- R1: While reset is asserted, and after it is released until a start is taken, `pclk_o`, `pdat_o`, `paux_o`, `prst_o`, `busy_o`, `done_o` and `word_ready_o` are all low.
- R2: A start pulse seen in idle makes `busy_o` and `word_ready_o` high in the next cycle; word 0 is taken on the first cycle with `word_valid_i` high. `mode_i` is latched at start: 0 standard entry, 1 standard entry with side-band level, 2 reset-line entry, 3 behaves as 0.
- R3: Standard entry (modes 0, 1, 3): clock high with data low for `T_CLK_LEAD` cycles, then both high for `T_BOTH_HI` cycles, then both low for `T_SETTLE` cycles.
- R4: Reset-line entry (mode 2): `prst_o` rises with clock and data low for `T_RST_SETUP` cycles, then clock high for `T_RST_CLK_HI`, then clock low for `T_RST_CLK_LO`; `prst_o` stays high until the cycle `done_o` is shown.
- R5: In mode 1, `paux_o` equals bit 0 of word 0 from the first entry cycle until the end of the session; in every other mode it stays low.
- R6: With `erase_wait_i` high at start, clock and data stay low for a further `T_ERASE` cycles after entry, before the first data bit.
- R7: Each of the 256 data bits is placed on `pdat_o` with the clock low for `T_HALF` cycles, then held while the clock is high for `T_HALF` cycles. Words go out from word 0 to word 15, bit 0 first, and `pdat_o` never falls while the clock stays high.
- R8: After the first, each word is requested only once the previous word's 16 bits and the gap are done. `word_ready_o` then stays high, with clock and data low, until `word_valid_i` is seen.
- R9: After every word except the last, clock and data stay low for `T_GAP` cycles before the next word is requested.
- R10: After the last bit's high phase, `done_o` is high for exactly one cycle, `busy_o` is low in that cycle and all line outputs are low.
- R11: A start pulse while a session runs is ignored: the session's timing, data and single `done_o` pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on the clock |
| start_i | input | 1 | Request to begin a programming session |
| mode_i | input | 2 | Entry variant, latched at start |
| erase_wait_i | input | 1 | Insert the erase wait after entry, latched at start |
| word_i | input | WORD_W | Next image word |
| word_valid_i | input | 1 | `word_i` holds a word |
| word_ready_o | output | 1 | The block takes `word_i` in this cycle when valid |
| busy_o | output | 1 | A session is in progress |
| done_o | output | 1 | One-cycle end-of-session pulse |
| pclk_o | output | 1 | Serial clock to the target |
| pdat_o | output | 1 | Serial data to the target |
| paux_o | output | 1 | Side-band level line (mode 1) |
| prst_o | output | 1 | Target reset/enable line (mode 2) |

## Verification
The properties check on every cycle that the lines are quiet outside a session and that data never falls while the clock stays high. They also check that the side-band line moves only when a word is taken, that the reset line drops only at the end, and that the end pulse is a single cycle following a busy stretch. Only the bench's scenarios can show the exact length of each entry phase, the erase and gap intervals, and bit-exact delivery of the image in word and bit order. The same goes for holding through feeder stalls and for recovery after a reset in mid-session.

// File: rtl/pes_pkg.sv
package pes_pkg;

  typedef enum logic [1:0] {
    ENTRY_STD = 2'd0,
    ENTRY_AUX = 2'd1,
    ENTRY_RST = 2'd2,
    ENTRY_ALT = 2'd3
  } entry_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_FETCH,
    S_CLKHI,
    S_BOTHHI,
    S_SETTLE,
    S_RSETUP,
    S_RCLKHI,
    S_RCLKLO,
    S_ERASE,
    S_BITLO,
    S_BITHI,
    S_GAP,
    S_DONE
  } seq_state_e;

endpackage

// File: rtl/pes_rst_sync.sv
module pes_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pes_timer.sv
module pes_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) begin
      cnt_d = load_val_i;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pes_shifter.sv
module pes_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              shift_i,
  output logic              bit_o,
  output logic              last_bit_o
);

  localparam int BCNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_d;
  logic [BCNT_W-1:0] bcnt_q;
  logic [BCNT_W-1:0] bcnt_d;
  logic              sh_en;

  always_comb begin
    sh_en  = load_i || shift_i;
    sh_d   = sh_q;
    bcnt_d = bcnt_q;
    if (load_i) begin
      sh_d   = load_word_i;
      bcnt_d = '0;
    end else if (shift_i) begin
      sh_d   = {1'b0, sh_q[WORD_W-1:1]};
      bcnt_d = bcnt_q + BCNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
    end else if (sh_en) begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign bit_o      = sh_q[0];
  assign last_bit_o = (bcnt_q == LAST_BIT);

endmodule

// File: rtl/prog_entry_seq.sv
module prog_entry_seq
  import pes_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int NUM_WORDS    = 16,
  parameter int T_CLK_LEAD   = 100,
  parameter int T_BOTH_HI    = 100,
  parameter int T_SETTLE     = 100,
  parameter int T_ERASE      = 5000,
  parameter int T_HALF       = 10,
  parameter int T_GAP        = 2000,
  parameter int T_RST_SETUP  = 100,
  parameter int T_RST_CLK_HI = 20,
  parameter int T_RST_CLK_LO = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              erase_wait_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pclk_o,
  output logic              pdat_o,
  output logic              paux_o,
  output logic              prst_o
);

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_DUR = max2(max2(max2(T_CLK_LEAD, T_BOTH_HI), max2(T_SETTLE, T_ERASE)),
                                max2(max2(T_HALF, T_GAP),
                                     max2(T_RST_SETUP, max2(T_RST_CLK_HI, T_RST_CLK_LO))));
  localparam int CNT_W  = $clog2(MAX_DUR) + 1;
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(NUM_WORDS - 1);

  function automatic logic [CNT_W-1:0] dur_of(input seq_state_e s);
    case (s)
      S_CLKHI:  return CNT_W'(T_CLK_LEAD - 1);
      S_BOTHHI: return CNT_W'(T_BOTH_HI - 1);
      S_SETTLE: return CNT_W'(T_SETTLE - 1);
      S_RSETUP: return CNT_W'(T_RST_SETUP - 1);
      S_RCLKHI: return CNT_W'(T_RST_CLK_HI - 1);
      S_RCLKLO: return CNT_W'(T_RST_CLK_LO - 1);
      S_ERASE:  return CNT_W'(T_ERASE - 1);
      S_BITLO:  return CNT_W'(T_HALF - 1);
      S_BITHI:  return CNT_W'(T_HALF - 1);
      S_GAP:    return CNT_W'(T_GAP - 1);
      default:  return '0;
    endcase
  endfunction

  logic        rst_int_n;
  seq_state_e  state_q, state_d;
  entry_e      mode_q;
  logic        erase_q;
  logic        first_q, first_d;
  logic [WIDX_W-1:0] widx_q, widx_d;
  logic        aux_q, aux_d;
  logic        prst_q, prst_d;
  logic        cfg_en, widx_en, first_en, aux_en, prst_en;
  logic        accept;
  logic        tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic        tmr_done;
  logic        bit_shift;
  logic        cur_bit;
  logic        last_bit;
  seq_state_e  after_entry;

  pes_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pes_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_done)
  );

  pes_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (accept),
    .load_word_i (word_i),
    .shift_i     (bit_shift),
    .bit_o       (cur_bit),
    .last_bit_o  (last_bit)
  );

  assign accept      = (state_q == S_FETCH) && word_valid_i;
  assign after_entry = erase_q ? S_ERASE : S_BITLO;

  // next-state decision
  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (start_i) state_d = S_FETCH;
      S_FETCH: begin
        if (accept) begin
          if (first_q) begin
            state_d = (mode_q == ENTRY_RST) ? S_RSETUP : S_CLKHI;
          end else begin
            state_d = S_BITLO;
          end
        end
      end
      S_CLKHI:  if (tmr_done) state_d = S_BOTHHI;
      S_BOTHHI: if (tmr_done) state_d = S_SETTLE;
      S_SETTLE: if (tmr_done) state_d = after_entry;
      S_RSETUP: if (tmr_done) state_d = S_RCLKHI;
      S_RCLKHI: if (tmr_done) state_d = S_RCLKLO;
      S_RCLKLO: if (tmr_done) state_d = after_entry;
      S_ERASE:  if (tmr_done) state_d = S_BITLO;
      S_BITLO:  if (tmr_done) state_d = S_BITHI;
      S_BITHI: begin
        if (tmr_done) begin
          if (!last_bit) begin
            state_d = S_BITLO;
          end else if (widx_q == LAST_WORD) begin
            state_d = S_DONE;
          end else begin
            state_d = S_GAP;
          end
        end
      end
      S_GAP:    if (tmr_done) state_d = S_FETCH;
      S_DONE:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  // side data paths and their enables
  always_comb begin
    tmr_load  = (state_d != state_q);
    tmr_val   = dur_of(state_d);
    bit_shift = (state_q == S_BITHI) && tmr_done;

    cfg_en    = (state_q == S_IDLE) && start_i;

    widx_en   = cfg_en || (bit_shift && last_bit && (state_d == S_GAP));
    widx_d    = cfg_en ? '0 : (widx_q + WIDX_W'(1));

    first_en  = cfg_en || accept;
    first_d   = cfg_en;

    aux_en    = (state_d == S_DONE) || (state_d == S_IDLE) || (accept && first_q);
    aux_d     = (accept && first_q && (mode_q == ENTRY_AUX)) ? word_i[0] : 1'b0;

    prst_en   = (state_d == S_RSETUP) || (state_d == S_DONE) || (state_d == S_IDLE);
    prst_d    = (state_d == S_RSETUP);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q  <= ENTRY_STD;
      erase_q <= 1'b0;
    end else if (cfg_en) begin
      mode_q  <= entry_e'(mode_i);
      erase_q <= erase_wait_i;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      widx_q <= '0;
    end else if (widx_en) begin
      widx_q <= widx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      first_q <= 1'b0;
    end else if (first_en) begin
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      aux_q <= 1'b0;
    end else if (aux_en) begin
      aux_q <= aux_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prst_q <= 1'b0;
    end else if (prst_en) begin
      prst_q <= prst_d;
    end
  end

  // line and status decode
  always_comb begin
    pclk_o       = (state_q == S_CLKHI) || (state_q == S_BOTHHI) ||
                   (state_q == S_RCLKHI) || (state_q == S_BITHI);
    pdat_o       = (state_q == S_BOTHHI) ||
                   (((state_q == S_BITLO) || (state_q == S_BITHI)) && cur_bit);
    paux_o       = aux_q;
    prst_o       = prst_q;
    word_ready_o = (state_q == S_FETCH);
    done_o       = (state_q == S_DONE);
    busy_o       = (state_q != S_IDLE) && (state_q != S_DONE);
  end

endmodule

// File: rtl/pes_checker.sv
module pes_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic word_ready_o,
  input logic busy_o,
  input logic done_o,
  input logic pclk_o,
  input logic pdat_o,
  input logic paux_o,
  input logic prst_o
);

  logic [2:0] arm_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= '0;
    end else begin
      arm_q <= {arm_q[1:0], 1'b1};
    end
  end

  assign armed = arm_q[2];

  AST_QUIET_OUTSIDE_SESSION: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !busy_o |-> (!pclk_o && !pdat_o && !paux_o && !prst_o && !word_ready_o)) else $error("quiet"); // R1

  AST_START_OPENS_FETCH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (start_i && !busy_o && !done_o) |=> (busy_o && word_ready_o)) else $error("start"); // R2

  AST_RST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (prst_o && busy_o) |=> (prst_o || done_o)) else $error("prst"); // R4

  AST_AUX_STEADY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (busy_o && $past(busy_o) && !$past(word_ready_o)) |-> $stable(paux_o)) else $error("aux"); // R5

  AST_NO_DATA_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (pclk_o && $past(pclk_o)) |-> !$fell(pdat_o)) else $error("data"); // R7

  AST_READY_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    word_ready_o |-> (busy_o && !pclk_o && !pdat_o)) else $error("ready"); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done_o |=> !done_o) else $error("done1"); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done2"); // R10

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (busy_o && start_i) |=> (busy_o || done_o)) else $error("restart"); // R11

endmodule

bind prog_entry_seq pes_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .word_ready_o (word_ready_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .pclk_o       (pclk_o),
  .pdat_o       (pdat_o),
  .paux_o       (paux_o),
  .prst_o       (prst_o)
);

// File: tb/sim_prog_entry_seq.sv
module sim_prog_entry_seq;

  localparam int TL = 3;
  localparam int TB = 4;
  localparam int TS = 5;
  localparam int TE = 7;
  localparam int TH = 2;
  localparam int TG = 3;
  localparam int RS = 4;
  localparam int RH = 3;
  localparam int RL = 2;

  // {mode[21:20], erase[19], stall[18:16], seed[15:0]}
  localparam logic [21:0] VECS [8] = '{
    {2'd0, 1'b0, 3'd0, 16'h1235},
    {2'd0, 1'b1, 3'd2, 16'hA5A4},
    {2'd1, 1'b0, 3'd0, 16'h0F0F},
    {2'd1, 1'b1, 3'd1, 16'hF0F0},
    {2'd2, 1'b0, 3'd3, 16'h3C3D},
    {2'd2, 1'b1, 3'd0, 16'h8000},
    {2'd3, 1'b0, 3'd1, 16'h0001},
    {2'd1, 1'b0, 3'd0, 16'hFFFE}
  };

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  mode_i;
  logic        erase_wait_i;
  logic [15:0] word_i;
  logic        word_valid_i;
  logic        word_ready_o, busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o;

  prog_entry_seq #(
    .WORD_W(16), .NUM_WORDS(16),
    .T_CLK_LEAD(TL), .T_BOTH_HI(TB), .T_SETTLE(TS), .T_ERASE(TE),
    .T_HALF(TH), .T_GAP(TG),
    .T_RST_SETUP(RS), .T_RST_CLK_HI(RH), .T_RST_CLK_LO(RL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .erase_wait_i(erase_wait_i), .word_i(word_i), .word_valid_i(word_valid_i),
    .word_ready_o(word_ready_o), .busy_o(busy_o), .done_o(done_o),
    .pclk_o(pclk_o), .pdat_o(pdat_o), .paux_o(paux_o), .prst_o(prst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [15:0] img [16];
  logic [15:0] cap [16];
  logic [3:0]  seg_tup [8];
  int          seg_len [8];
  int          nseg, busy_cnt, done_cnt, aux_bad, prst_bad, rise_cnt;
  logic [3:0]  last_tup;
  logic        prev_clk;
  logic        mon_en;
  logic        exp_aux, exp_prst;
  logic        feed_abort;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // line monitor: run-length segments, side-line levels and bits at rising clock
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (done_o) done_cnt++;
        if (busy_o) begin
          busy_cnt++;
          if (nseg == 0 || {prst_o, paux_o, pclk_o, pdat_o} != last_tup) begin
            if (nseg < 8) begin
              seg_tup[nseg] = {prst_o, paux_o, pclk_o, pdat_o};
              seg_len[nseg] = 1;
            end
            nseg++;
            last_tup = {prst_o, paux_o, pclk_o, pdat_o};
          end else if (nseg <= 8) begin
            seg_len[nseg-1]++;
          end
          if (nseg >= 2) begin
            if (paux_o !== exp_aux) aux_bad++;
            if (prst_o !== exp_prst) prst_bad++;
          end
          if (pclk_o && !prev_clk) begin
            rise_cnt++;
            if (rise_cnt >= 2 && rise_cnt <= 257)
              cap[(rise_cnt-2)/16][(rise_cnt-2)%16] = pdat_o;
          end
          prev_clk = pclk_o;
        end else begin
          prev_clk = 1'b0;
        end
      end
    end
  end

  task automatic feed(input int stall);
    for (int w = 0; w < 16; w++) begin
      if (w == 0) begin
        word_i = img[0];
        word_valid_i = 1'b1;
      end else begin
        word_valid_i = 1'b0;
        do @(negedge clk); while (!word_ready_o && !feed_abort);
        repeat (stall) @(negedge clk);
        word_i = img[w];
        word_valid_i = 1'b1;
      end
      while (!(word_ready_o && word_valid_i) && !feed_abort) @(negedge clk);
      if (feed_abort) break;
      @(posedge clk);
      #1;
    end
    word_valid_i = 1'b0;
  endtask

  task automatic poke_start();
    repeat (200) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic load_image(input logic [15:0] seed);
    for (int w = 0; w < 16; w++) begin
      img[w] = seed ^ 16'(w * 16'h2F1B);
      cap[w] = 16'h0;
    end
  endtask

  task automatic clear_mon();
    nseg = 0; busy_cnt = 0; done_cnt = 0; aux_bad = 0; prst_bad = 0;
    rise_cnt = 0; prev_clk = 1'b0; last_tup = 4'h0;
    for (int i = 0; i < 8; i++) begin
      seg_tup[i] = 4'h0;
      seg_len[i] = 0;
    end
  endtask

  task automatic run_vector(input logic [1:0] mode, input logic erase,
                            input int stall, input logic [15:0] seed, input bit poke);
    int t;
    int entry, e_cyc, exp_busy;
    logic b0;
    logic [3:0] e_tup [4];
    int e_len [4];
    load_image(seed);
    b0 = seed[0];
    exp_aux  = (mode == 2'd1) ? b0 : 1'b0;
    exp_prst = (mode == 2'd2);
    e_cyc = erase ? TE : 0;
    clear_mon();
    feed_abort = 1'b0;
    mon_en = 1'b1;
    fork
      feed(stall);
    join_none
    @(negedge clk);
    mode_i = mode;
    erase_wait_i = erase;
    start_i = 1'b1;
    if (poke) begin
      fork
        poke_start();
      join_none
    end
    @(negedge clk);
    start_i = 1'b0;
    // R2: next cycle after start, session running and word 0 requested
    check(busy_o && word_ready_o, "R2", "busy/ready after start",
          {busy_o, word_ready_o}, 3);
    t = 0;
    while (!done_o && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(t < 5000, "R10", "session ended", t, 0);
    repeat (3) @(negedge clk);
    mon_en = 1'b0;

    e_tup[0] = 4'b0000; e_len[0] = 1;
    if (mode == 2'd2) begin
      entry = RS + RH + RL;
      e_tup[1] = 4'b1000; e_len[1] = RS;
      e_tup[2] = 4'b1010; e_len[2] = RH;
      e_tup[3] = 4'b1000; e_len[3] = RL + e_cyc + (b0 ? 0 : TH);
    end else begin
      entry = TL + TB + TS;
      e_tup[1] = {1'b0, exp_aux, 2'b10}; e_len[1] = TL;
      e_tup[2] = {1'b0, exp_aux, 2'b11}; e_len[2] = TB;
      e_tup[3] = {1'b0, exp_aux, 2'b00}; e_len[3] = TS + e_cyc + (b0 ? 0 : TH);
    end
    for (int i = 0; i < 4; i++) begin
      check(seg_tup[i] == e_tup[i], (mode == 2'd2) ? "R4" : "R3", "entry segment lines",
            int'(seg_tup[i]), int'(e_tup[i]));
      check(seg_len[i] == e_len[i], (i == 3 && erase) ? "R6" : ((mode == 2'd2) ? "R4" : "R3"),
            "entry segment length", seg_len[i], e_len[i]);
    end
    for (int w = 0; w < 16; w++) begin
      check(cap[w] == img[w], "R7", "received word", int'(cap[w]), int'(img[w]));
    end
    check(rise_cnt == 257, "R7", "clock rises", rise_cnt, 257);
    check(aux_bad == 0, "R5", "side-band level cycles wrong", aux_bad, 0);
    check(prst_bad == 0, "R4", "reset line cycles wrong", prst_bad, 0);
    exp_busy = 1 + entry + e_cyc + 16 * 16 * 2 * TH + 15 * (TG + 1 + stall);
    check(busy_cnt == exp_busy, poke ? "R11" : "R9", "busy cycles (gap and R8 stalls)",
          busy_cnt, exp_busy);
    check(done_cnt == 1, poke ? "R11" : "R10", "done pulses", done_cnt, 1);
    check({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o} == 7'b0,
          "R10", "lines after end",
          int'({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    mode_i = 2'd0;
    erase_wait_i = 1'b0;
    word_i = 16'h0;
    word_valid_i = 1'b0;
    mon_en = 1'b0;
    feed_abort = 1'b0;
    exp_aux = 1'b0;
    exp_prst = 1'b0;
    clear_mon();
    repeat (3) @(negedge clk);
    // R1: during reset
    check({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o} == 7'b0,
          "R1", "outputs in reset",
          int'({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o} == 7'b0,
          "R1", "outputs after release",
          int'({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o}), 0);

    for (int v = 0; v < 8; v++) begin
      run_vector(VECS[v][21:20], VECS[v][19], int'(VECS[v][18:16]), VECS[v][15:0], 1'b0);
      repeat (2) @(negedge clk);
    end

    // R11: start pulses during a running session
    run_vector(2'd0, 1'b0, 0, 16'h5A5B, 1'b1);
    repeat (5) @(negedge clk);
    check(!busy_o, "R11", "no restart after end", int'(busy_o), 0);

    // R1: reset in the middle of a session
    load_image(16'h7E7F);
    feed_abort = 1'b0;
    fork
      feed(0);
    join_none
    @(negedge clk);
    mode_i = 2'd2;
    erase_wait_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (300) @(negedge clk);
    rst_n = 1'b0;
    feed_abort = 1'b1;
    repeat (2) @(negedge clk);
    check({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o} == 7'b0,
          "R1", "outputs in mid-session reset",
          int'({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o}), 0);
    word_valid_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o} == 7'b0,
          "R1", "outputs after mid-session reset",
          int'({busy_o, done_o, pclk_o, pdat_o, paux_o, prst_o, word_ready_o}), 0);

    // recovery: a full session after the reset
    run_vector(2'd1, 1'b1, 1, 16'hC3C3, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule